// File: doc/BRIEF.md
# Nine-Bit Serial Receive Address Filter

This block sits behind the deserializer of an 8051-style serial receiver. The receiver works in its nine-bit or ten-bit-frame modes. The deserializer hands over one finished frame at a time: eight data bits, a ninth bit and the sampled stop bit. For each frame the block decides two things: whether to load the receive buffer and raise the receive flag, and whether to record a framing error.

The accept decision depends on three conditions: whether the receive flag is already up, whether the multiprocessor filter is enabled, and the frame's ninth bit. When the filter is on in nine-bit mode, a frame whose ninth bit is 1 is treated as an address. It is accepted only if its bits under the mask equal the masked own address, or if it carries 1s in every bit of the broadcast pattern (own address OR mask). A slave waiting to be addressed keeps the filter enabled. Once addressed, software clears the enable so that the data frames that follow are loaded.

The frame input is a valid/ready stream. `frm_ready` is low during reset and then stays high, so the deserializer is never back-pressured. A frame is consumed in every cycle where `frm_valid` is high, whether it is accepted or dropped. The deserializer must not hold `frm_valid` high for longer than the one cycle that each frame takes.

Top module: `uart_addr_filter`

## Requirements
- R1: While `rst_n` is low, `frm_ready`, `buf_load`, `rx_flag`, `rx_bit8`, `frame_err` and `rx_buf` are all 0.
- R2: With `mp_filter_en`=0 and `rx_flag` low, a consumed frame is accepted. One cycle later `buf_load` is high for exactly one cycle, `rx_buf` holds the data, `rx_flag` is 1 and `rx_bit8` holds the ninth bit.
- R3: A frame consumed while `rx_flag` is 1 is dropped: there is no `buf_load`, and `rx_buf` and `rx_bit8` keep their values.
- R4: With `mp_filter_en`=1 and `nine_bit_mode`=1, a frame whose `frm_bit9` is 0 is dropped.
- R5: With `mp_filter_en`=1 and `nine_bit_mode`=1, an address frame (`frm_bit9`=1) whose data ANDed with `addr_mask` equals `own_addr` ANDed with `addr_mask` is accepted. Otherwise it is dropped, unless R6 applies.
- R6: An address frame whose data has a 1 in every bit that is 1 in (`own_addr` OR `addr_mask`) is a broadcast and is accepted.
- R7: When `addr_mask` is all zeros, every address frame is accepted.
- R8: With `nine_bit_mode`=0, the stop bit takes the place of the ninth bit: it goes to `rx_bit8`, and with the filter enabled a frame with stop 0 is dropped. No address compare is made in this mode.
- R9: A consumed frame with `frm_stop`=0 sets `frame_err` one cycle later, whether or not the frame is accepted. The error does not stop the frame from being accepted.
- R10: `frame_err` holds until a cycle with `ferr_clr`=1, and a new error in that same cycle wins over the clear. `rx_flag_clr` clears `rx_flag` one cycle later.
- R11: After reset `frm_ready` rises and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A completed frame is present |
| frm_ready | output | 1 | Frame is consumed (high after reset) |
| frm_data | input | 8 | Eight received data bits |
| frm_bit9 | input | 1 | Received ninth bit |
| frm_stop | input | 1 | Sampled stop bit (1 = valid) |
| nine_bit_mode | input | 1 | 1: nine-bit frames; 0: eight-bit frames |
| mp_filter_en | input | 1 | Multiprocessor filter enable |
| own_addr | input | 8 | Slave address |
| addr_mask | input | 8 | Address compare mask (1 = compare bit) |
| rx_flag_clr | input | 1 | Clear the receive flag |
| ferr_clr | input | 1 | Clear the framing-error flag |
| buf_load | output | 1 | One-cycle pulse when the buffer is loaded |
| rx_buf | output | 8 | Receive buffer |
| rx_flag | output | 1 | Receive flag |
| rx_bit8 | output | 1 | Ninth bit (or stop bit) of the last accepted frame |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Every result is due on the clock edge that follows the edge which consumes the frame: `buf_load`, `rx_buf`, `rx_bit8`, `rx_flag` and `frame_err` all come from one register stage. The clears follow the same one-edge rule. Each bench task drives a frame on a falling edge and drops `frm_valid` on the next falling edge. It then samples the outputs at that falling edge, which comes just after the one register stage has updated. Dropped frames are checked the same way: `buf_load` must be low and the buffer unchanged in that sample.

// File: rtl/uart_addr_filter_pkg.sv
package uart_addr_filter_pkg;
  typedef enum logic [1:0] {
    FR_DATA      = 2'd0,
    FR_ADDR_HIT  = 2'd1,
    FR_ADDR_MISS = 2'd2,
    FR_BLOCKED   = 2'd3
  } frame_class_t;
endpackage

// File: rtl/uaf_addr_match.sv
module uaf_addr_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] own,
  input  logic [W-1:0] mask,
  output logic         hit_given,
  output logic         hit_bcast
);
  logic [W-1:0] given_ok;
  logic [W-1:0] bcast_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // compared bit must equal own address bit; unmasked bit is free
    assign given_ok[i] = ~mask[i] | (data[i] == own[i]);
    // broadcast bit must be 1 unless both own and mask are 0
    assign bcast_ok[i] = data[i] | ~(own[i] | mask[i]);
  end

  assign hit_given = &given_ok;
  assign hit_bcast = &bcast_ok;
endmodule

// File: rtl/uaf_accept.sv
module uaf_accept
  import uart_addr_filter_pkg::*;
(
  input  logic         nine_bit_mode,
  input  logic         mp_filter_en,
  input  logic         flag_now,
  input  logic         bit9,
  input  logic         stop,
  input  logic         hit_given,
  input  logic         hit_bcast,
  output logic         ninth,
  output frame_class_t cls,
  output logic         accept
);
  always_comb begin
    ninth = nine_bit_mode ? bit9 : stop;
    if (!mp_filter_en)                cls = FR_DATA;
    else if (!ninth)                  cls = FR_BLOCKED;
    else if (!nine_bit_mode)          cls = FR_DATA;
    else if (hit_given || hit_bcast)  cls = FR_ADDR_HIT;
    else                              cls = FR_ADDR_MISS;
    accept = !flag_now && (cls == FR_DATA || cls == FR_ADDR_HIT);
  end
endmodule

// File: rtl/uaf_status.sv
module uaf_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         accept,
  input  logic         bad_stop,
  input  logic [W-1:0] data,
  input  logic         ninth,
  input  logic         rx_flag_clr,
  input  logic         ferr_clr,
  output logic         ready,
  output logic         buf_load,
  output logic [W-1:0] rx_buf,
  output logic         rx_flag,
  output logic         rx_bit8,
  output logic         frame_err
);
  logic take;
  assign take = fire & accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      buf_load  <= 1'b0;
      rx_buf    <= '0;
      rx_flag   <= 1'b0;
      rx_bit8   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      ready    <= 1'b1;
      buf_load <= take;
      if (take) begin
        rx_buf  <= data;
        rx_bit8 <= ninth;
      end
      if (take)             rx_flag <= 1'b1;
      else if (rx_flag_clr) rx_flag <= 1'b0;
      if (fire && bad_stop) frame_err <= 1'b1;
      else if (ferr_clr)    frame_err <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import uart_addr_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              frm_stop,
  input  logic              nine_bit_mode,
  input  logic              mp_filter_en,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              rx_flag_clr,
  input  logic              ferr_clr,
  output logic              buf_load,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_flag,
  output logic              rx_bit8,
  output logic              frame_err
);
  logic         hit_given, hit_bcast, ninth, accept, fire;
  frame_class_t cls;

  assign fire = frm_valid & frm_ready;

  uaf_addr_match #(.W(DATA_W)) u_match (
    .data(frm_data), .own(own_addr), .mask(addr_mask),
    .hit_given(hit_given), .hit_bcast(hit_bcast)
  );

  uaf_accept u_accept (
    .nine_bit_mode(nine_bit_mode), .mp_filter_en(mp_filter_en),
    .flag_now(rx_flag), .bit9(frm_bit9), .stop(frm_stop),
    .hit_given(hit_given), .hit_bcast(hit_bcast),
    .ninth(ninth), .cls(cls), .accept(accept)
  );

  uaf_status #(.W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .fire(fire), .accept(accept),
    .bad_stop(~frm_stop), .data(frm_data), .ninth(ninth),
    .rx_flag_clr(rx_flag_clr), .ferr_clr(ferr_clr),
    .ready(frm_ready), .buf_load(buf_load), .rx_buf(rx_buf),
    .rx_flag(rx_flag), .rx_bit8(rx_bit8), .frame_err(frame_err)
  );
endmodule

// File: rtl/uart_addr_filter_chk.sv
module uart_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic              frm_bit9,
  input logic              frm_stop,
  input logic              nine_bit_mode,
  input logic              mp_filter_en,
  input logic              ferr_clr,
  input logic              buf_load,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_flag,
  input logic              frame_err
);
  // R2
  load_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |-> rx_flag);
  // R3
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> !buf_load);
  // R3
  busy_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> $stable(rx_buf));
  // R4
  data_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && mp_filter_en && nine_bit_mode && !frm_bit9) |=> !buf_load);
  // R9
  stop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !frm_stop) |=> frame_err);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !ferr_clr) |=> frame_err);
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |=> frm_ready);
endmodule

bind uart_addr_filter uart_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_bit9(frm_bit9), .frm_stop(frm_stop), .nine_bit_mode(nine_bit_mode),
  .mp_filter_en(mp_filter_en), .ferr_clr(ferr_clr), .buf_load(buf_load),
  .rx_buf(rx_buf), .rx_flag(rx_flag), .frame_err(frame_err)
);

// File: tb/uart_addr_filter_bench.sv
module uart_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_ready;
  logic [7:0] frm_data = 8'h00;
  logic       frm_bit9 = 1'b0;
  logic       frm_stop = 1'b1;
  logic       nine_bit_mode = 1'b1;
  logic       mp_filter_en = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic [7:0] addr_mask = 8'h00;
  logic       rx_flag_clr = 1'b0;
  logic       ferr_clr = 1'b0;
  logic       buf_load, rx_flag, rx_bit8, frame_err;
  logic [7:0] rx_buf;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  uart_addr_filter u_uart_addr_filter (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic st);
    @(negedge clk);
    frm_data = d; frm_bit9 = b9; frm_stop = st; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0; frm_stop = 1'b1;
  endtask

  task automatic clear_flag();
    @(negedge clk); rx_flag_clr = 1'b1;
    @(negedge clk); rx_flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 ready", frm_ready, 0);
    chk("R1 outs", {buf_load, rx_flag, rx_bit8, frame_err, rx_buf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready up", frm_ready, 1);
  endtask

  task automatic t_plain();
    mp_filter_en = 0; nine_bit_mode = 1;
    send(8'hA5, 0, 1);
    chk("R2 load", buf_load, 1);
    chk("R2 buf", rx_buf, 8'hA5);
    chk("R2 flag/bit8", {rx_flag, rx_bit8}, 2'b10);
    @(negedge clk);
    chk("R2 single pulse", buf_load, 0);
    clear_flag();
    chk("R10 flag cleared", rx_flag, 0);
    send(8'h3C, 1, 1);
    chk("R2 bit8 one", {buf_load, rx_bit8, rx_buf}, {2'b11, 8'h3C});
  endtask

  task automatic t_busy();
    send(8'h99, 0, 1);
    chk("R3 no load", buf_load, 0);
    chk("R3 held", {rx_bit8, rx_buf}, {1'b1, 8'h3C});
    chk("R11 ready stays", frm_ready, 1);
    clear_flag();
  endtask

  task automatic t_filter();
    mp_filter_en = 1; own_addr = 8'h12; addr_mask = 8'hF0;
    send(8'h10, 0, 1);
    chk("R4 data dropped", {buf_load, rx_flag}, 0);
    send(8'h1F, 1, 1);
    chk("R5 given hit", {buf_load, rx_buf}, {1'b1, 8'h1F});
    clear_flag();
    send(8'h2F, 1, 1);
    chk("R5 miss", {buf_load, rx_flag}, 0);
    send(8'hF0, 1, 1);
    chk("R6 partial bcast miss", {buf_load, rx_flag}, 0);
    send(8'hF7, 1, 1);
    chk("R6 bcast hit", {buf_load, rx_buf}, {1'b1, 8'hF7});
    clear_flag();
    addr_mask = 8'h00; own_addr = 8'h00;
    send(8'h00, 1, 1);
    chk("R7 zero mask", {buf_load, rx_buf}, {1'b1, 8'h00});
    clear_flag();
  endtask

  task automatic t_mode8();
    nine_bit_mode = 0; mp_filter_en = 1; own_addr = 8'h12; addr_mask = 8'hF0;
    send(8'h33, 1, 0);
    chk("R8 stop0 dropped", {buf_load, rx_flag}, 0);
    chk("R9 err on drop", frame_err, 1);
    send(8'h55, 0, 1);
    chk("R8 no addr compare", {buf_load, rx_bit8, rx_buf}, {2'b11, 8'h55});
    clear_flag();
    @(negedge clk); ferr_clr = 1; @(negedge clk); ferr_clr = 0;
    chk("R10 err cleared", frame_err, 0);
    nine_bit_mode = 1;
  endtask

  task automatic t_ferr();
    mp_filter_en = 0;
    send(8'h81, 0, 0);
    chk("R9 err and accept", {buf_load, rx_flag, frame_err, rx_buf}, {3'b111, 8'h81});
    clear_flag();
    repeat (3) @(negedge clk);
    chk("R10 err sticky", frame_err, 1);
    @(negedge clk); ferr_clr = 1; @(negedge clk); ferr_clr = 0;
    chk("R10 err clr", frame_err, 0);
    @(negedge clk);
    frm_data = 8'h42; frm_bit9 = 0; frm_stop = 0; frm_valid = 1; ferr_clr = 1;
    @(negedge clk);
    frm_valid = 0; frm_stop = 1; ferr_clr = 0;
    chk("R10 set wins", frame_err, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_plain(); t_busy(); t_filter(); t_mode8(); t_ferr();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule